// File: doc/BRIEF.md
# High ROM Shadow Remap Unit

This block sits on a 24-bit memory request path and redirects accesses aimed at the top of the address space into shadow RAM. A single enable bit is held in a small configuration register. While that bit is set, any request whose address lands in the high ROM window comes out with its upper address nibble cleared. A fetch at FFFFF0H therefore reaches shadow RAM at 0FFFF0H. The block also raises a set of override flags that the downstream memory decode must obey. These flags select shadow RAM, suppress ROM and expansion-bus cycles, skip expanded-memory paging and request an early wait state. A write-inhibit flag is also raised when shadow RAM is write-protected.

Requests enter on a valid/ready port and leave through a single-entry registered slice with its own valid/ready port. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the slice is empty, or whenever the consumer is draining it in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value. The window size, the power-good clear and the write protect are plain control pins.

Top module: `hirom_remap`

## Requirements
- R1: For a translated access, `rsp_addr[23:20]` is 0 and `rsp_addr[19:0]` equals the request address bits 19:0. For example, FFFFF0H becomes 0FFFF0H.
- R2: With `win_sel`=0 the window is FF0000H..FFFFFFH. With `win_sel`=1 it is FE0000H..FFFFFFH. Addresses FEFFFFH and FDFFFFH lie outside the 64 KB window, and FDFFFFH also lies outside the 128 KB window.
- R3: When the enable is 0 or the address is outside the window, `rsp_addr` equals the request address. In that case `rsp_shadow_sel`, `rsp_bus_suppress`, `rsp_wr_inhibit`, `rsp_page_bypass` and `rsp_early_wait` are all 0.
- R4: A translated read or write raises both `rsp_shadow_sel` and `rsp_bus_suppress`.
- R5: `rsp_wr_inhibit` is 1 exactly when the access is translated, is a write (`req_write`=1), and `shadow_wp` is 1.
- R6: Every translated access raises `rsp_page_bypass`.
- R7: Every translated access raises `rsp_early_wait`.
- R8: `req_master` does not change translation. The response is the same as for a CPU access, and `rsp_master` echoes the request's `req_master` value.
- R9: The enable resets to 0. A rising edge with `cfg_we`=1 and `pwr_good`=1 loads the enable from `cfg_wdata` bit 5.
- R10: While `pwr_good` is 0, the enable is cleared at once, without waiting for a clock edge, and writes to it are ignored.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, all response outputs keep their values. After reset `rsp_valid` is 0.
- R12: An accepted request is translated using the enable value from before that edge. A configuration write on the same edge only affects later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Power good; low clears the enable asynchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data; bit 5 is the enable |
| win_sel | input | 1 | Window size: 0 = 64 KB, 1 = 128 KB |
| shadow_wp | input | 1 | Shadow RAM write protect |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 24 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | 1 | 1 = bus master access, 0 = CPU |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_addr | output | 24 | Translated address |
| rsp_write | output | 1 | Echo of request direction |
| rsp_master | output | 1 | Echo of master indicator |
| rsp_shadow_sel | output | 1 | Route access to shadow RAM |
| rsp_bus_suppress | output | 1 | Forbid ROM and expansion-bus cycles |
| rsp_wr_inhibit | output | 1 | Block the write |
| rsp_page_bypass | output | 1 | Skip expanded-memory page mapping |
| rsp_early_wait | output | 1 | Early wait state request |

## Verification
The hardest case to reach from the ports is a power-good drop that lands between clock edges. This must be followed by a configuration write while power is still bad, and then by requests that would have hit the window. The stimulus lowers `pwr_good` one nanosecond after an edge, issues a write with bit 5 set during the low period, and then sends high addresses. It expects them to pass through untouched. Two other situations need deliberate timing. One is a configuration write on the same edge as an accepted request. The other is a stalled response slice that keeps its value for several cycles while new requests wait. Both are produced by directed sequences, and a long randomized phase follows that mixes all inputs.

// File: rtl/hrr_pkg.sv
package hrr_pkg;
  localparam int ADDR_W = 24;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              write;
    logic              master;
    logic              shadow_sel;
    logic              bus_suppress;
    logic              wr_inhibit;
    logic              page_bypass;
    logic              early_wait;
  } hrr_rsp_t;
endpackage

// File: rtl/hrr_cfg_reg.sv
module hrr_cfg_reg #(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              en
);
  logic clr_n;
  logic en_q;

  assign clr_n = rst_n & pwr_good;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) en_q <= 1'b0;
    else if (we) en_q <= wdata[EN_BIT];
  end

  assign en = en_q;

  // R10: low power-good always leaves the enable cleared
  a_r10_pg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> !en_q);
  // R9: an accepted write loads the enable bit
  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pwr_good) |=> (!pwr_good || en_q == $past(wdata[EN_BIT])));
endmodule

// File: rtl/hrr_window_decode.sv
module hrr_window_decode #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              hit
);
  localparam int NARROW_TOP = ADDR_W - WIN_LOG2;
  localparam int WIDE_TOP   = NARROW_TOP - 1;

  logic narrow_hit, wide_hit;

  assign narrow_hit = &addr[ADDR_W-1:WIN_LOG2];
  assign wide_hit   = &addr[ADDR_W-1:WIN_LOG2+1];
  assign hit        = wide ? wide_hit : narrow_hit;

  // R2: a hit always has the wide-window prefix all ones
  always_comb begin
    if (hit) a_r2_prefix: assert (addr[ADDR_W-1:ADDR_W-WIDE_TOP] == '1);
  end
endmodule

// File: rtl/hrr_xlate.sv
module hrr_xlate
  import hrr_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic              en,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              master,
  input  logic              wp,
  output hrr_rsp_t          rsp
);
  localparam int KEEP_W = ADDR_W - NIB_W;

  logic xl;

  assign xl = en & hit;

  always_comb begin
    rsp.addr         = xl ? {{NIB_W{1'b0}}, addr[KEEP_W-1:0]} : addr;
    rsp.write        = write;
    rsp.master       = master;
    rsp.shadow_sel   = xl;
    rsp.bus_suppress = xl;
    rsp.wr_inhibit   = xl & write & wp;
    rsp.page_bypass  = xl;
    rsp.early_wait   = xl;
  end

  // R1: low bits kept on translation
  always_comb begin
    if (xl) a_r1_low_kept: assert (rsp.addr[KEEP_W-1:0] == addr[KEEP_W-1:0]);
  end
endmodule

// File: rtl/hrr_out_slice.sv
module hrr_out_slice
  import hrr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  hrr_rsp_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output hrr_rsp_t out_data
);
  logic     v_q;
  hrr_rsp_t d_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;

  // R11: stalled response holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R11: accepted request becomes visible
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/hirom_remap.sv
module hirom_remap
  import hrr_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 5,
  parameter int WIN_LOG2 = 16,
  parameter int NIB_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              win_sel,
  input  logic              shadow_wp,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_master,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_write,
  output logic              rsp_master,
  output logic              rsp_shadow_sel,
  output logic              rsp_bus_suppress,
  output logic              rsp_wr_inhibit,
  output logic              rsp_page_bypass,
  output logic              rsp_early_wait
);
  logic     en, hit;
  hrr_rsp_t nxt, cur;

  hrr_cfg_reg #(.DATA_W(CFG_W), .EN_BIT(EN_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .we(cfg_we), .wdata(cfg_wdata), .en(en));

  hrr_window_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .addr(req_addr), .wide(win_sel), .hit(hit));

  hrr_xlate #(.NIB_W(NIB_W)) u_xl (
    .en(en), .hit(hit), .addr(req_addr), .write(req_write),
    .master(req_master), .wp(shadow_wp), .rsp(nxt));

  hrr_out_slice u_slice (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_data(nxt), .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_data(cur));

  assign rsp_addr         = cur.addr;
  assign rsp_write        = cur.write;
  assign rsp_master       = cur.master;
  assign rsp_shadow_sel   = cur.shadow_sel;
  assign rsp_bus_suppress = cur.bus_suppress;
  assign rsp_wr_inhibit   = cur.wr_inhibit;
  assign rsp_page_bypass  = cur.page_bypass;
  assign rsp_early_wait   = cur.early_wait;

  // R1: routed-to-shadow responses have a cleared top nibble
  a_r1_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_shadow_sel) |-> (rsp_addr[ADDR_W-1:ADDR_W-NIB_W] == '0));
  // R5: inhibit only on routed writes
  a_r5_inhibit_scope: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_inhibit |-> (rsp_shadow_sel && rsp_write));
  // R12: disabled before the edge means no translation for that request
  a_r12_old_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !en) |=> !rsp_shadow_sel);
endmodule

// File: tb/sim_hirom_remap.sv
`timescale 1ns/100ps
module sim_hirom_remap;
  logic clk = 0, rst_n = 0, pwr_good = 1, cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic win_sel = 0, shadow_wp = 0, req_valid = 0, req_write = 0, req_master = 0;
  logic rsp_ready = 1;
  logic [23:0] req_addr = 0;
  logic req_ready, rsp_valid, rsp_write, rsp_master, rsp_shadow_sel;
  logic rsp_bus_suppress, rsp_wr_inhibit, rsp_page_bypass, rsp_early_wait;
  logic [23:0] rsp_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hirom_remap u0 (.*);

  // reference model
  logic m_en = 0, m_v = 0;
  logic [23:0] m_addr = 0;
  logic m_wr = 0, m_ms = 0, m_xl = 0, m_wi = 0;

  always @(negedge pwr_good) m_en = 0;

  always @(posedge clk) begin
    logic rdy, nen, inwin;
    if (!rst_n) begin
      m_en = 0; m_v = 0; m_addr = 0; m_wr = 0; m_ms = 0; m_xl = 0; m_wi = 0;
    end else begin
      rdy = !m_v || rsp_ready;
      nen = m_en;
      if (cfg_we && pwr_good) nen = cfg_wdata[5];
      if (!pwr_good) nen = 0;
      if (rdy) begin
        m_v = req_valid;
        if (req_valid) begin
          inwin = win_sel ? (req_addr >= 24'hFE0000) : (req_addr >= 24'hFF0000);
          m_xl = m_en && inwin;
          m_addr = m_xl ? (req_addr & 24'h0FFFFF) : req_addr;
          m_wr = req_write; m_ms = req_master;
          m_wi = m_xl && req_write && shadow_wp;
        end
      end
      m_en = nen;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(req_ready == (!m_v || rsp_ready), "R11 ready", req_ready, !m_v || rsp_ready);
    chk(rsp_valid == m_v, "R11 valid", rsp_valid, m_v);
    if (m_v) begin
      chk(rsp_addr == m_addr, m_xl ? "R1 addr" : "R3 addr", rsp_addr, m_addr);
      chk(rsp_shadow_sel == m_xl, "R4 shadow", rsp_shadow_sel, m_xl);
      chk(rsp_bus_suppress == m_xl, "R4 suppress", rsp_bus_suppress, m_xl);
      chk(rsp_wr_inhibit == m_wi, "R5 inhibit", rsp_wr_inhibit, m_wi);
      chk(rsp_page_bypass == m_xl, "R6 bypass", rsp_page_bypass, m_xl);
      chk(rsp_early_wait == m_xl, "R7 wait", rsp_early_wait, m_xl);
      chk(rsp_write == m_wr && rsp_master == m_ms, "R8 echo",
          {rsp_write, rsp_master}, {m_wr, m_ms});
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(bit e);
    cfg_we = 1; cfg_wdata = e ? 8'h20 : 8'hDF; cyc(); cfg_we = 0;
  endtask

  task automatic acc(logic [23:0] a, bit w, bit m);
    req_valid = 1; req_addr = a; req_write = w; req_master = m;
    cyc(); req_valid = 0;
  endtask

  task automatic expect_addr(string tag, logic [23:0] e, bit sel);
    @(negedge clk);
    chk(rsp_addr == e && rsp_shadow_sel == sel, tag, {rsp_shadow_sel, rsp_addr}, {sel, e});
    cyc();
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=finish");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk(rsp_valid == 0 && req_ready == 1, "R11 reset", {rsp_valid, req_ready}, 2'b01);
    rst_n = 1; cyc();
    // R9: default disabled
    acc(24'hFFFFF0, 0, 0); expect_addr("R9 default off", 24'hFFFFF0, 0);
    cfg(1);
    acc(24'hFFFFF0, 0, 0); expect_addr("R1 FFFFF0", 24'h0FFFF0, 1);
    acc(24'hFEFFFF, 0, 0); expect_addr("R2 narrow miss", 24'hFEFFFF, 0);
    acc(24'hFF0000, 0, 0); expect_addr("R2 narrow edge", 24'h0F0000, 1);
    win_sel = 1;
    acc(24'hFEFFFF, 0, 0); expect_addr("R2 wide hit", 24'h0EFFFF, 1);
    acc(24'hFE0000, 0, 0); expect_addr("R2 wide edge", 24'h0E0000, 1);
    acc(24'hFDFFFF, 0, 0); expect_addr("R3 wide miss", 24'hFDFFFF, 0);
    shadow_wp = 1;
    acc(24'hFFFF00, 1, 0); @(negedge clk);
    chk(rsp_wr_inhibit == 1, "R5 wp write", rsp_wr_inhibit, 1); cyc();
    acc(24'h0FFF00, 1, 0); @(negedge clk);
    chk(rsp_wr_inhibit == 0, "R5 low addr write", rsp_wr_inhibit, 0); cyc();
    shadow_wp = 0;
    acc(24'hFFFF00, 1, 1); @(negedge clk);
    chk(rsp_wr_inhibit == 0 && rsp_shadow_sel == 1 && rsp_master == 1, "R8 master write",
        {rsp_wr_inhibit, rsp_shadow_sel, rsp_master}, 3'b011); cyc();
    // R12: disable on same edge as accept
    cfg_we = 1; cfg_wdata = 8'h00; acc(24'hFFFFF0, 0, 0); cfg_we = 0;
    expect_addr("R12 old enable used", 24'h0FFFF0, 1);
    acc(24'hFFFFF0, 0, 0); expect_addr("R12 new enable", 24'hFFFFF0, 0);
    // R11 stall
    cfg(1); rsp_ready = 0;
    acc(24'hFFFF10, 0, 0);
    req_valid = 1; req_addr = 24'h000123; cyc(4);
    @(negedge clk);
    chk(rsp_addr == 24'h0FFF10 && req_ready == 0, "R11 stall hold", rsp_addr, 24'h0FFF10);
    rsp_ready = 1; cyc(); req_valid = 0; cyc();
    // R10 power-good drop
    pwr_good = 0; cyc();
    cfg(1);
    pwr_good = 1; cyc();
    acc(24'hFFFFF0, 0, 0); expect_addr("R10 cleared and write ignored", 24'hFFFFF0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      req_valid = $urandom_range(0, 1);
      req_addr = ($urandom_range(0, 3) != 0) ? (24'hFC0000 | 24'($urandom_range(0, 24'h3FFFF)))
                                             : 24'($urandom);
      req_write = $urandom_range(0, 1); req_master = $urandom_range(0, 1);
      win_sel = $urandom_range(0, 1); shadow_wp = $urandom_range(0, 1);
      rsp_ready = ($urandom_range(0, 3) != 0);
      cfg_we = ($urandom_range(0, 15) == 0); cfg_wdata = 8'($urandom);
      pwr_good = ($urandom_range(0, 63) != 0);
      cyc();
    end
    req_valid = 0; cfg_we = 0; pwr_good = 1; rsp_ready = 1; cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule